// File: doc/BRIEF.md
# Pulse-Position Symbol Encoder

This block is the transmit side of a reader-to-tag link. It takes data bytes over a valid/ready handshake and turns each one into pause-request timing for a carrier modulator. The block runs on the carrier clock. A byte is split into bit pairs. Each pair becomes one symbol of four equal slots, and exactly one slot carries a pause. The pause fills the second half of the slot whose index equals the pair's value. Pairs go out least significant first. While the producer keeps a byte waiting, consecutive bytes follow each other with no idle cycle between them.

Control is a two-state machine. `ENC_IDLE` waits with `in_ready` high. The transition *launch* (IDLE to SEND) fires when a byte is accepted. `ENC_SEND` times the 4096-cycle byte. At the last cycle of a byte there are two possible transitions. *Chain* (SEND to SEND) fires if a new byte is accepted in that cycle. *Drain* (SEND to IDLE) fires if no byte is waiting. A symbol timer, a pair shifter and a pause comparator sit under the machine.

Top module: `ppm_symbol_encoder`

## Requirements
- R1: A symbol lasts 1024 clock cycles and is made of four slots of 256 cycles each. A byte uses four symbols, so 4096 cycles in total. Byte cycle 0 is the first clock cycle after the accepting edge.
- R2: A pair value p (0..3) drives `mod_out` high for exactly 128 cycles. The pause covers symbol offsets 256·p+128 through 256·p+255, so it starts at offset 128, 384, 640 or 896 for p = 0, 1, 2 or 3.
- R3: Symbol k of a byte (k = 0..3) carries data bits [2k+1:2k], so the least significant pair goes first. For example, byte E1h gives pair values 1, 0, 2, 3.
- R4: `busy` is high for every one of the 4096 cycles of a byte and low otherwise.
- R5: `in_ready` is high when idle and in the last cycle of a byte, and low in every other busy cycle. A byte is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- R6: If a byte is accepted in the last cycle of the previous byte, its cycle 0 follows with no gap.
- R7: `mod_out` is low outside the pause windows and whenever `busy` is low.
- R8: `in_valid` and `in_data` have no effect on `mod_out`, `busy` or `in_ready` while `in_ready` is low.
- R9: While `rst_n` is low, the block is idle, with `mod_out` low, `busy` low and `in_ready` high. A reset in the middle of a byte drops the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a byte |
| in_ready | output | 1 | Encoder can take a byte this cycle |
| in_data | input | 8 | Byte to send |
| mod_out | output | 1 | Active-high carrier pause request |
| busy | output | 1 | A byte is being sent |

## Verification
The main function is tried with several bytes whose four pairs are all equal (00h, FFh), so that slot placement is checked without any dependence on ordering. It is also tried with bytes whose pairs are all different in both directions (1Bh, E4h), which exposes a reversed pair order. Mixed bytes (E1h, A5h, 9Ch) catch partial swaps and repeated slots. Every cycle of every byte is compared with the expected pause waveform, so a shifted window, a wrong pause length or a missing gap shows up as a mismatch. A chained stream of three bytes separates gap-free chaining from a return to idle. A byte offered while busy with different data shows that early input is ignored, and a reset in mid-byte shows that the block recovers cleanly.

// File: rtl/ppm_enc_pkg.sv
package ppm_enc_pkg;

    typedef enum logic [0:0] {
        ENC_IDLE = 1'b0,
        ENC_SEND = 1'b1
    } enc_state_e;

    localparam int unsigned SLOTS_PER_SYM = 4;
    localparam int unsigned BITS_PER_SYM  = 2;

endpackage

// File: rtl/ppm_slot_timer.sv
module ppm_slot_timer #(
    parameter int unsigned SLOT_CYC  = 256,
    parameter int unsigned PAUSE_CYC = 128,
    parameter int unsigned SYMS      = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    output logic [1:0] slot_idx,
    output logic       in_tail,
    output logic       sym_end,
    output logic       frame_end
);
    localparam int unsigned SLOT_W = $clog2(SLOT_CYC);
    localparam int unsigned SYM_W  = (SYMS > 1) ? $clog2(SYMS) : 1;
    localparam logic [SLOT_W-1:0] PH_LAST  = SLOT_W'(SLOT_CYC - 1);
    localparam logic [SLOT_W-1:0] PH_TAIL  = SLOT_W'(SLOT_CYC - PAUSE_CYC);
    localparam logic [SYM_W-1:0]  SYM_LAST = SYM_W'(SYMS - 1);

    logic [SLOT_W-1:0] phase_q;
    logic [1:0]        slot_q;
    logic [SYM_W-1:0]  sym_q;
    logic              slot_wrap;

    assign slot_wrap = (phase_q == PH_LAST);
    assign sym_end   = run && slot_wrap && (slot_q == 2'd3);
    assign frame_end = sym_end && (sym_q == SYM_LAST);
    assign slot_idx  = slot_q;
    assign in_tail   = (phase_q >= PH_TAIL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            slot_q  <= '0;
            sym_q   <= '0;
        end else if (restart) begin
            phase_q <= '0;
            slot_q  <= '0;
            sym_q   <= '0;
        end else if (run) begin
            if (slot_wrap) begin
                phase_q <= '0;
                slot_q  <= slot_q + 2'd1;
                if (slot_q == 2'd3) begin
                    sym_q <= (sym_q == SYM_LAST) ? '0 : sym_q + SYM_W'(1);
                end
            end else begin
                phase_q <= phase_q + SLOT_W'(1);
            end
        end
    end
endmodule

// File: rtl/ppm_pair_shifter.sv
module ppm_pair_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              advance,
    output logic [1:0]        pair
);
    logic [DATA_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_data;
        end else if (advance) begin
            sr_q <= sr_q >> ppm_enc_pkg::BITS_PER_SYM;
        end
    end

    assign pair = sr_q[1:0];
endmodule

// File: rtl/ppm_pause_gen.sv
module ppm_pause_gen (
    input  logic       active,
    input  logic [1:0] slot_idx,
    input  logic [1:0] pair,
    input  logic       in_tail,
    output logic       mod
);
    always_comb begin
        mod = active && in_tail && (slot_idx == pair);
    end
endmodule

// File: rtl/ppm_symbol_encoder.sv
module ppm_symbol_encoder #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned SLOT_CYC  = 256,
    parameter int unsigned PAUSE_CYC = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              mod_out,
    output logic              busy
);
    import ppm_enc_pkg::*;

    localparam int unsigned SYMS = DATA_W / BITS_PER_SYM;

    enc_state_e state_q, state_d;
    logic       accept;
    logic       running;
    logic [1:0] slot_idx;
    logic [1:0] pair;
    logic       in_tail;
    logic       sym_end;
    logic       frame_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENC_IDLE: if (accept)    state_d = ENC_SEND;                      // launch
            ENC_SEND: if (frame_end) state_d = accept ? ENC_SEND : ENC_IDLE;  // chain / drain
        endcase
    end

    always_comb begin
        running  = 1'b0;
        in_ready = 1'b0;
        unique case (state_q)
            ENC_IDLE: begin
                running  = 1'b0;
                in_ready = 1'b1;
            end
            ENC_SEND: begin
                running  = 1'b1;
                in_ready = frame_end;
            end
        endcase
    end

    assign accept = in_valid && in_ready;
    assign busy   = running;

    ppm_slot_timer #(
        .SLOT_CYC (SLOT_CYC),
        .PAUSE_CYC(PAUSE_CYC),
        .SYMS     (SYMS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (accept),
        .run      (running),
        .slot_idx (slot_idx),
        .in_tail  (in_tail),
        .sym_end  (sym_end),
        .frame_end(frame_end)
    );

    ppm_pair_shifter #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_data(in_data),
        .advance  (sym_end),
        .pair     (pair)
    );

    ppm_pause_gen u_pause (
        .active  (running),
        .slot_idx(slot_idx),
        .pair    (pair),
        .in_tail (in_tail),
        .mod     (mod_out)
    );
endmodule

// File: rtl/ppm_encoder_checker.sv
module ppm_encoder_checker #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned SLOT_CYC  = 256,
    parameter int unsigned PAUSE_CYC = 128
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic mod_out,
    input logic busy
);
    localparam int unsigned BYTE_CYC = SLOT_CYC * 4 * (DATA_W / 2);
    localparam int unsigned POS_W    = $clog2(BYTE_CYC);
    localparam int unsigned RUN_W    = $clog2(PAUSE_CYC + 1) + 1;
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(BYTE_CYC - 1);

    logic [POS_W-1:0] pos_q;
    logic [RUN_W-1:0] run_q;
    logic             acc;

    assign acc = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            run_q <= '0;
        end else begin
            if (acc)       pos_q <= '0;
            else if (busy) pos_q <= pos_q + POS_W'(1);
            run_q <= mod_out ? run_q + RUN_W'(1) : '0;
        end
    end

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> busy);                                                      // R5
    AST_READY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_ready) |-> (pos_q == POS_LAST));                        // R5
    AST_BUSY_FULL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(pos_q) == POS_LAST));                        // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mod_out);                                                // R7
    AST_PAUSE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mod_out |-> ((pos_q % SLOT_CYC) >= (SLOT_CYC - PAUSE_CYC)));        // R2
    AST_PAUSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_out) |-> (run_q == RUN_W'(PAUSE_CYC)));                   // R2
    AST_PAUSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        mod_out |-> (run_q < RUN_W'(PAUSE_CYC)));                           // R2
endmodule

bind ppm_symbol_encoder ppm_encoder_checker #(
    .DATA_W   (DATA_W),
    .SLOT_CYC (SLOT_CYC),
    .PAUSE_CYC(PAUSE_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .mod_out (mod_out),
    .busy    (busy)
);

// File: tb/tb_ppm_symbol_encoder.sv
`timescale 1ns/1ps
module tb_ppm_symbol_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       mod_out;
    logic       busy;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    ppm_symbol_encoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .mod_out(mod_out), .busy(busy)
    );

    // byte, then expected pair of symbol 0..3 as hex nibbles (symbol 0 leftmost)
    localparam logic [23:0] VEC [7] = '{
        {8'hE1, 16'h1023}, {8'h00, 16'h0000}, {8'hFF, 16'h3333},
        {8'h1B, 16'h3210}, {8'hE4, 16'h0123}, {8'hA5, 16'h1122},
        {8'h9C, 16'h0312}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Entry: at a negedge with in_valid/in_data set and in_ready expected high.
    task automatic run_byte(input logic [7:0] b, input logic [15:0] syms,
                            input bit chain, input logic [7:0] nxt,
                            input bit noise, input string tag);
        int mod_bad = 0, busy_bad = 0, rdy_bad = 0, first_bad = -1;
        check(in_ready === 1'b1, "R5", {tag, " ready before accept"}, int'(in_ready), 1);
        @(posedge clk);
        for (int i = 0; i < 4096; i++) begin
            @(negedge clk);
            begin
                int sym = i / 1024;
                int pos = i % 1024;
                int pr  = int'(syms[(3 - sym) * 4 +: 2]);
                bit exp = ((pos / 256) == pr) && ((pos % 256) >= 128);
                if (mod_out !== exp) begin
                    mod_bad++;
                    if (first_bad < 0) first_bad = i;
                end
                if (busy !== 1'b1) busy_bad++;
                if (in_ready !== (i == 4095)) rdy_bad++;
            end
            if (i == 0) in_valid = 1'b0;
            if (noise && i == 1000) begin in_valid = 1'b1; in_data = ~b; end
            if (noise && i == 3000) in_valid = 1'b0;
            if (chain && i == 4095) begin in_valid = 1'b1; in_data = nxt; end
        end
        check(mod_bad == 0, "R2/R3", {tag, " pause waveform mismatches (first at cycle shown)"},
              first_bad, -1);
        check(busy_bad == 0, "R4", {tag, " busy low cycles"}, busy_bad, 0);
        check(rdy_bad == 0, "R5", {tag, " ready wrong cycles"}, rdy_bad, 0);
    endtask

    task automatic check_idle(input string tag);
        @(negedge clk);
        check(busy === 1'b0, "R4", {tag, " busy after byte"}, int'(busy), 0);
        check(mod_out === 1'b0, "R7", {tag, " mod idle"}, int'(mod_out), 0);
        check(in_ready === 1'b1, "R5", {tag, " ready idle"}, int'(in_ready), 1);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check(mod_out === 1'b0 && busy === 1'b0 && in_ready === 1'b1, "R9",
              "reset outputs", {mod_out, busy, in_ready}, 3'b001);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R7: idle with no valid stays quiet for a while
        begin
            int noisy = 0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (mod_out !== 1'b0 || busy !== 1'b0) noisy++;
            end
            check(noisy == 0, "R7", "idle quiet", noisy, 0);
        end

        // R1 R2 R3: table of single bytes, each followed by a drain to idle
        for (int v = 0; v < 7; v++) begin
            in_valid = 1'b1;
            in_data  = VEC[v][23:16];
            run_byte(VEC[v][23:16], VEC[v][15:0], 1'b0, 8'h00, 1'b0, $sformatf("vec%0d", v));
            check_idle($sformatf("vec%0d", v));
            repeat (5) @(negedge clk);
        end

        // R6: three bytes chained with no gap
        in_valid = 1'b1; in_data = 8'h4E;
        run_byte(8'h4E, 16'h2301, 1'b1, 8'h71, 1'b0, "R6 chain0");
        run_byte(8'h71, 16'h1031, 1'b1, 8'hC8, 1'b0, "R6 chain1");
        run_byte(8'hC8, 16'h0203, 1'b0, 8'h00, 1'b0, "R6 chain2");
        check_idle("R6 drain");

        // R8: valid with other data while busy is ignored
        in_valid = 1'b1; in_data = 8'hE1;
        run_byte(8'hE1, 16'h1023, 1'b0, 8'h00, 1'b1, "R8 noise");
        check_idle("R8 after noise");

        // R9: reset in mid-byte drops it
        in_valid = 1'b1; in_data = 8'hFF;
        @(posedge clk);
        @(negedge clk); in_valid = 1'b0;
        repeat (900) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(mod_out === 1'b0 && busy === 1'b0 && in_ready === 1'b1, "R9",
              "mid-byte reset outputs", {mod_out, busy, in_ready}, 3'b001);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        check(busy === 1'b0 && mod_out === 1'b0, "R9", "stays idle after reset",
              {mod_out, busy}, 0);
        in_valid = 1'b1; in_data = 8'h1B;
        run_byte(8'h1B, 16'h3210, 1'b0, 8'h00, 1'b0, "R1 after reset");
        check_idle("R1 after reset");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule